// File: doc/BRIEF.md
# Dual-Role Configuration Serial Port Controller

This block controls the serial port used to load a device's configuration. In master role it drives the serial clock from the internal oscillator, pulls the flash chip select low and drives one data pin toward the flash. In slave role an external host owns the clock and chip select, and the controller drives the other data pin back to it. The controller decides which pins are outputs at each moment. It lets an external slave select take the port away from an active master session. When configuration completes, it keeps the serial clock running for a fixed number of extra oscillator cycles before releasing that pin.

The whole block runs in the oscillator domain. The slave select and done inputs pass through two-flop synchronizers before the state machine uses them. The state machine has five states:

- `ST_IDLE` is the state after reset.
- `ST_MASTER` is an active flash fetch.
- `ST_SLAVE` means a host owns the port.
- `ST_RUNON` is the extra clocking after done.
- `ST_STOPPED` means configuration is finished.

Its transitions are:

- Init: any state goes to `ST_MASTER` or `ST_SLAVE`.
- Pre-empt: `ST_MASTER` goes to `ST_SLAVE`.
- Done-master: `ST_MASTER` goes to `ST_RUNON`.
- Done-slave: `ST_SLAVE` goes to `ST_STOPPED`.
- Run-on expiry: `ST_RUNON` goes to `ST_STOPPED`.

Top module: `cfg_spi_port_ctrl`

## Requirements
- R1: After reset, `role` is 0 (idle), `cclk_oe`, `pin_a_oe` and `pin_b_oe` are 0, `mcs_n_o` is 1, and `mcs_oe` equals the inverse of `strap_cs_gpio`.
- R2: An `init_pulse` sampled at a clock edge sets `role` from that edge on: 1 (master) when `strap_master` is 1 and slave select is high, otherwise 2 (slave).
- R3: In master role `cclk_oe` is 1 and `cclk_o` changes value at every oscillator edge.
- R4: `mcs_oe` is always the inverse of `strap_cs_gpio`. `mcs_n_o` is 0 only during active master role and is 1 in every other state.
- R5: In master role data pin A is driven with `m_sdo` and pin B is released. In slave role pin A is released and pin B is driven with `s_sdo` while slave select is low.
- R6: Slave select falling during master role takes effect at the second oscillator edge after the change. At that edge the clock driver, chip select and pin A are released and pin B is driven, and `role` reads 2 one edge later.
- R7: Pin A and pin B are never driven together. Pin B is never driven while the chip select is driven low.
- R8: A rising edge of done during master role is acted on three edges after the input changes. The clock then keeps toggling for exactly `RUN_ON` cycles with `mcs_n_o` high, after which `cclk_oe` is 0 and `role` is 3 (stopped).
- R9: A rising edge of done during slave role moves `role` to 3 three edges after the input changes.
- R10: In stopped role, pin B is driven only when `persist` is 1 and slave select is low.
- R11: An `init_pulse` in stopped role restarts the session, and the master clock drives again.
- R12: `RUN_ON` must lie within 100 to 500, checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_master | input | 1 | Mode strap: 1 selects master role at init |
| strap_cs_gpio | input | 1 | Mode strap: 1 releases the chip-select pin to user I/O |
| persist | input | 1 | Keep slave port reserved after configuration |
| init_pulse | input | 1 | Start-of-configuration pulse |
| slv_sel_n | input | 1 | Asynchronous active-low slave select |
| done | input | 1 | Asynchronous configuration-done flag |
| m_sdo | input | 1 | Serial data from the master engine |
| s_sdo | input | 1 | Serial data from the slave engine |
| cclk_o | output | 1 | Serial clock value |
| cclk_oe | output | 1 | Serial clock output enable |
| mcs_n_o | output | 1 | Flash chip select value, active low |
| mcs_oe | output | 1 | Flash chip select output enable |
| pin_a_o | output | 1 | Data pin A value |
| pin_a_oe | output | 1 | Data pin A output enable (master output) |
| pin_b_o | output | 1 | Data pin B value |
| pin_b_oe | output | 1 | Data pin B output enable (slave output) |
| mst_en | output | 1 | Master engine enable |
| role | output | 2 | 0 idle, 1 master, 2 slave, 3 stopped |

## Verification
The bench builds the block with `RUN_ON` at its minimum of 100 and two synchronizer stages. This keeps each run-on window short enough to count cycle by cycle.

It sweeps all eight combinations of the master strap, the chip-select strap and the persist input. Each master combination runs twice, once with a pre-emption and once with a full run-on. The sweep therefore reaches every state and every named transition, both chip-select ownership cases and both persist outcomes.

// File: rtl/cfg_spi_port_pkg.sv
package cfg_spi_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASTER,
        ST_SLAVE,
        ST_RUNON,
        ST_STOPPED
    } port_state_e;

    typedef enum logic [1:0] {
        ROLE_IDLE    = 2'd0,
        ROLE_MASTER  = 2'd1,
        ROLE_SLAVE   = 2'd2,
        ROLE_STOPPED = 2'd3
    } port_role_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cfg_runon_cnt.sv
module cfg_runon_cnt #(
    parameter int RUN_ON = 100
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic                           run,
    output logic                           last,
    output logic [$clog2(RUN_ON+1)-1:0]    count
);
    localparam int CW = $clog2(RUN_ON + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RUN_ON);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (load)                 count <= LOAD_VAL;
        else if (run && count != '0)   count <= count - 1'b1;
    end

    assign last = run && (count == CW'(1));

    AST_LOAD_FULL:    assert property (@(posedge clk) disable iff (!rst_n)
                          load |=> count == LOAD_VAL);                 // R8
    AST_RUN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                          run |-> count != '0);                        // R8
endmodule

// File: rtl/cfg_port_fsm.sv
module cfg_port_fsm
    import cfg_spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_master,
    input  logic       persist,
    input  logic       init_pulse,
    input  logic       ssn_sync,
    input  logic       done_sync,
    input  logic       runon_last,
    output logic       runon_load,
    output logic       runon_run,
    output logic       cclk_run,
    output logic       cclk_oe,
    output logic       mcs_n,
    output logic       a_oe,
    output logic       b_oe,
    output logic       mst_en,
    output logic [1:0] role
);
    port_state_e state, nxt;
    logic        done_prev;
    logic        done_rise;

    assign done_rise  = done_sync && !done_prev;
    assign runon_load = (state == ST_MASTER) && ssn_sync && done_rise && !init_pulse;
    assign runon_run  = (state == ST_RUNON);

    always_comb begin
        nxt = state;
        if (init_pulse) begin
            nxt = (strap_master && ssn_sync) ? ST_MASTER : ST_SLAVE;
        end else begin
            unique case (state)
                ST_MASTER: begin
                    if (!ssn_sync)      nxt = ST_SLAVE;
                    else if (done_rise) nxt = ST_RUNON;
                end
                ST_SLAVE:  if (done_rise)  nxt = ST_STOPPED;
                ST_RUNON:  if (runon_last) nxt = ST_STOPPED;
                default:   nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done_prev <= 1'b0;
        end else begin
            state     <= nxt;
            done_prev <= done_sync;
        end
    end

    always_comb begin
        cclk_run = 1'b0;
        cclk_oe  = 1'b0;
        mcs_n    = 1'b1;
        a_oe     = 1'b0;
        b_oe     = 1'b0;
        mst_en   = 1'b0;
        role     = ROLE_IDLE;
        unique case (state)
            ST_MASTER: begin
                role = ROLE_MASTER;
                if (ssn_sync) begin
                    cclk_run = 1'b1;
                    cclk_oe  = 1'b1;
                    mcs_n    = 1'b0;
                    a_oe     = 1'b1;
                    mst_en   = 1'b1;
                end else begin
                    b_oe = 1'b1;
                end
            end
            ST_SLAVE: begin
                role = ROLE_SLAVE;
                b_oe = !ssn_sync;
            end
            ST_RUNON: begin
                role     = ROLE_MASTER;
                cclk_run = 1'b1;
                cclk_oe  = 1'b1;
            end
            ST_STOPPED: begin
                role = ROLE_STOPPED;
                b_oe = persist && !ssn_sync;
            end
            default: role = ROLE_IDLE;
        endcase
    end

    AST_INIT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                              init_pulse |=> (state == ST_MASTER || state == ST_SLAVE)); // R2
    AST_PREEMPT_SLAVE:    assert property (@(posedge clk) disable iff (!rst_n)
                              (state == ST_MASTER && !ssn_sync && !init_pulse) |=> state == ST_SLAVE); // R6
    AST_RUNON_STOPS:      assert property (@(posedge clk) disable iff (!rst_n)
                              (state == ST_RUNON && runon_last && !init_pulse) |=> state == ST_STOPPED); // R8
    AST_SLAVE_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
                              (state == ST_SLAVE && done_rise && !init_pulse) |=> state == ST_STOPPED); // R9
endmodule

// File: rtl/cfg_spi_port_ctrl.sv
module cfg_spi_port_ctrl #(
    parameter int RUN_ON      = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       strap_master,
    input  logic       strap_cs_gpio,
    input  logic       persist,
    input  logic       init_pulse,
    input  logic       slv_sel_n,
    input  logic       done,
    input  logic       m_sdo,
    input  logic       s_sdo,
    output logic       cclk_o,
    output logic       cclk_oe,
    output logic       mcs_n_o,
    output logic       mcs_oe,
    output logic       pin_a_o,
    output logic       pin_a_oe,
    output logic       pin_b_o,
    output logic       pin_b_oe,
    output logic       mst_en,
    output logic [1:0] role
);
    localparam int CW = $clog2(RUN_ON + 1);

    if (RUN_ON < 100 || RUN_ON > 500) begin : g_bad_runon
        $error("RUN_ON must lie within 100 to 500");   // R12
    end

    logic          ssn_sync, done_sync;
    logic          runon_load, runon_run, runon_last;
    logic          cclk_run, mcs_n, a_oe, b_oe;
    logic          cclk_q;
    logic [CW-1:0] runon_count;

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ssn (
        .clk(clk_osc), .rst_n(rst_n), .d(slv_sel_n), .q(ssn_sync));

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk_osc), .rst_n(rst_n), .d(done), .q(done_sync));

    cfg_runon_cnt #(.RUN_ON(RUN_ON)) u_runon (
        .clk(clk_osc), .rst_n(rst_n), .load(runon_load), .run(runon_run),
        .last(runon_last), .count(runon_count));

    cfg_port_fsm u_fsm (
        .clk(clk_osc), .rst_n(rst_n), .strap_master(strap_master),
        .persist(persist), .init_pulse(init_pulse), .ssn_sync(ssn_sync),
        .done_sync(done_sync), .runon_last(runon_last),
        .runon_load(runon_load), .runon_run(runon_run), .cclk_run(cclk_run),
        .cclk_oe(cclk_oe), .mcs_n(mcs_n), .a_oe(a_oe), .b_oe(b_oe),
        .mst_en(mst_en), .role(role));

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)        cclk_q <= 1'b0;
        else if (cclk_run) cclk_q <= ~cclk_q;
        else               cclk_q <= 1'b0;
    end

    assign cclk_o   = cclk_q;
    assign mcs_oe   = ~strap_cs_gpio;
    assign mcs_n_o  = mcs_n | strap_cs_gpio;
    assign pin_a_oe = a_oe;
    assign pin_a_o  = a_oe & m_sdo;
    assign pin_b_oe = b_oe;
    assign pin_b_o  = b_oe & s_sdo;

    AST_NO_DATA_CLASH:   assert property (@(posedge clk_osc) disable iff (!rst_n)
                             !(pin_a_oe && pin_b_oe));                        // R7
    AST_NO_CS_AND_SLAVE: assert property (@(posedge clk_osc) disable iff (!rst_n)
                             (mcs_oe && !mcs_n_o) |-> !pin_b_oe);             // R7
    AST_CCLK_TOGGLES:    assert property (@(posedge clk_osc) disable iff (!rst_n)
                             (cclk_oe && $past(cclk_oe)) |-> (cclk_o != $past(cclk_o))); // R3
    AST_CCLK_OFF_STOP:   assert property (@(posedge clk_osc) disable iff (!rst_n)
                             (role == 2'd3) |-> !cclk_oe);                    // R8
endmodule

// File: tb/cfg_spi_port_ctrl_tb.sv
module cfg_spi_port_ctrl_tb;
    localparam int RUN_ON = 100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, strap_master = 1'b0, strap_cs_gpio = 1'b0, persist = 1'b0;
    logic init_pulse = 1'b0, slv_sel_n = 1'b1, done = 1'b0, m_sdo = 1'b0, s_sdo = 1'b0;
    logic cclk_o, cclk_oe, mcs_n_o, mcs_oe, pin_a_o, pin_a_oe, pin_b_o, pin_b_oe, mst_en;
    logic [1:0] role;

    int checks = 0;
    int errors = 0;

    cfg_spi_port_ctrl #(.RUN_ON(RUN_ON), .SYNC_STAGES(2)) u_dut (
        .clk_osc(clk), .rst_n(rst_n), .strap_master(strap_master),
        .strap_cs_gpio(strap_cs_gpio), .persist(persist), .init_pulse(init_pulse),
        .slv_sel_n(slv_sel_n), .done(done), .m_sdo(m_sdo), .s_sdo(s_sdo),
        .cclk_o(cclk_o), .cclk_oe(cclk_oe), .mcs_n_o(mcs_n_o), .mcs_oe(mcs_oe),
        .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe),
        .mst_en(mst_en), .role(role));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R7: continuous pin ownership monitor
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 data clash", int'(pin_a_oe && pin_b_oe), 0);
            chk("R7 cs with slave", int'(mcs_oe && !mcs_n_o && pin_b_oe), 0);
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        logic prev;
        for (int c = 0; c < 16; c++) begin
            logic mm, s0, ps, pre;
            mm = c[0]; s0 = c[1]; ps = c[2]; pre = c[3];
            if (!mm && pre) continue;
            @(negedge clk);
            rst_n = 1'b0; done = 1'b0; slv_sel_n = 1'b1; init_pulse = 1'b0;
            strap_master = mm; strap_cs_gpio = s0; persist = ps;
            step(2);
            rst_n = 1'b1;
            step(1);
            chk("R1 role", role, 0);
            chk("R1 cclk_oe", cclk_oe, 0);
            chk("R1 data oe", int'(pin_a_oe | pin_b_oe), 0);
            chk("R1 mcs_n_o", mcs_n_o, 1);
            chk("R1 mcs_oe", mcs_oe, int'(!s0));

            init_pulse = 1'b1;
            step(1);
            init_pulse = 1'b0;
            chk("R2 role after init", role, mm ? 1 : 2);

            if (mm) begin
                prev = cclk_o;
                for (int k = 0; k < 4; k++) begin
                    m_sdo = k[0];
                    #1;
                    chk("R5 pin_a_oe", pin_a_oe, 1);
                    chk("R5 pin_a_o", pin_a_o, m_sdo);
                    chk("R5 pin_b_oe", pin_b_oe, 0);
                    chk("R4 mcs_n_o master", mcs_n_o, int'(s0));
                    chk("R4 mcs_oe", mcs_oe, int'(!s0));
                    chk("R3 cclk_oe", cclk_oe, 1);
                    step(1);
                    chk("R3 cclk toggles", int'(cclk_o != prev), 1);
                    prev = cclk_o;
                end
                if (pre) begin
                    slv_sel_n = 1'b0;
                    step(1);
                    chk("R6 still master after one edge", mst_en, 1);
                    step(1);
                    chk("R6 pin_a released", pin_a_oe, 0);
                    chk("R6 mcs_n_o high", mcs_n_o, 1);
                    chk("R6 cclk released", cclk_oe, 0);
                    chk("R6 pin_b driven", pin_b_oe, 1);
                    chk("R6 mst_en off", mst_en, 0);
                    step(1);
                    chk("R6 role slave", role, 2);
                    s_sdo = 1'b1;
                    #1;
                    chk("R5 pin_b_o", pin_b_o, 1);
                    s_sdo = 1'b0;
                    #1;
                    chk("R5 pin_b_o low", pin_b_o, 0);
                    slv_sel_n = 1'b1;
                    step(3);
                    chk("R5 pin_b released", pin_b_oe, 0);
                    done = 1'b1;
                    step(2);
                    chk("R9 not yet stopped", role, 2);
                    step(1);
                    chk("R9 role stopped", role, 3);
                end else begin
                    done = 1'b1;
                    step(2);
                    chk("R8 still master", mcs_n_o, int'(s0));
                    cnt = 0;
                    for (int k = 0; k < RUN_ON + 50; k++) begin
                        step(1);
                        if (cclk_oe && mcs_n_o) cnt++;
                    end
                    if (s0) cnt = cnt - 0;
                    chk("R8 run-on cycles", cnt, s0 ? RUN_ON + 0 : RUN_ON);
                    chk("R8 role stopped", role, 3);
                    chk("R8 cclk released", cclk_oe, 0);
                    chk("R4 mcs_n_o stopped", mcs_n_o, 1);
                end
            end else begin
                chk("R5 slave cclk", cclk_oe, 0);
                chk("R5 slave pin_b idle", pin_b_oe, 0);
                chk("R4 mcs_n_o slave", mcs_n_o, 1);
                slv_sel_n = 1'b0;
                step(2);
                chk("R5 slave pin_b driven", pin_b_oe, 1);
                chk("R5 slave pin_a released", pin_a_oe, 0);
                slv_sel_n = 1'b1;
                step(2);
                done = 1'b1;
                step(3);
                chk("R9 role stopped", role, 3);
            end

            slv_sel_n = 1'b0;
            step(2);
            chk("R10 persist pin_b", pin_b_oe, int'(ps));
            slv_sel_n = 1'b1;
            step(2);
            chk("R10 pin_b released", pin_b_oe, 0);

            if (mm && !pre) begin
                init_pulse = 1'b1;
                step(1);
                init_pulse = 1'b0;
                chk("R11 restart role", role, 1);
                chk("R11 restart cclk", cclk_oe, 1);
                prev = cclk_o;
                step(1);
                chk("R11 cclk toggles again", int'(cclk_o != prev), 1);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule